// File: doc/BRIEF.md
# Multi-Digit Decimal Adder-Subtractor

This block adds or subtracts two packed decimal numbers, each held as a row of four-bit digit codes (0 to 9 per nibble), and returns a packed decimal result with a decimal carry. It is purely combinational. A parameter sets the number of digits. Each digit position first adds in plain binary. When that binary total goes past nine, a correction step adds six and passes a carry to the next digit. Carries move upward from the lowest digit.

To subtract, every digit of the second operand goes through a mapper that replaces digit d with 9 − d. The carry into the lowest digit is then forced high, so the block computes A − B + 10^N. A negative difference is left in tens-complement form. In that mode a carry-out of 1 means no borrow occurred. The result for nibbles holding 10 to 15 is not defined, but a separate flag reports any such nibble on either operand.

Top module: `bcd_addsub`

## Requirements
- R1: With `sub_i` = 0 and all nibbles valid, `sum_o` holds (A + B + `cin_i`) mod 10^N as packed decimal, digit 0 in bits [3:0]. `cout_o` is 1 exactly when A + B + `cin_i` ≥ 10^N.
- R2: With all input nibbles valid, every nibble of `sum_o` lies in 0 to 9.
- R3: When a digit's binary total Z of the two digits plus the incoming carry exceeds 9, the result digit is Z − 10 and that digit's carry is 1. Otherwise the digit is Z and the carry is 0. For example, 9 + 9 + 1 gives digit 9 with carry 1.
- R4: Digit carries ripple from the lowest digit upward. For example, 9999 + 0001 gives 0000 with `cout_o` = 1.
- R5: With `sub_i` = 1 and all nibbles valid, `sum_o` holds (A − B + 10^N) mod 10^N and `cout_o` is 1 exactly when A ≥ B. In this mode `cin_i` has no effect.
- R6: When A < B in subtract mode, the result is the tens complement of B − A. For example, 0 − 1 gives 9999 with `cout_o` = 0.
- R7: `bad_digit_o` is 1 exactly when some nibble of `a_i` or `b_i` is greater than 9, whatever the value of `sub_i`.
- R8: The subtract mapper turns each subtrahend digit d into 9 − d. So 9999 − B yields, in every digit, nine minus the matching digit of B, with `cout_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4*DIGITS | First operand, packed decimal, digit 0 lowest |
| b_i | input | 4*DIGITS | Second operand (subtrahend in subtract mode) |
| sub_i | input | 1 | 1 selects A − B, 0 selects A + B + cin |
| cin_i | input | 1 | Carry into digit 0 in add mode |
| sum_o | output | 4*DIGITS | Packed decimal result |
| cout_o | output | 1 | Decimal carry out of the top digit (no-borrow in subtract mode) |
| bad_digit_o | output | 1 | Some operand nibble is above 9 |

## Verification
The checker runs on every input change and checks the following:
- each digit's carry agrees with its binary total going past nine;
- each result digit equals that total minus ten when corrected;
- totals stay within 19 and result digits within 0 to 9 for valid operands;
- subtract mode seeds the chain with a carry;
- the invalid-digit flag matches an independent nibble scan.

Whole-number correctness needs the bench's scenarios: sums modulo 10^N, tens-complement differences, rippling through a row of nines, and `cin_i` being ignored during subtraction. The bench checks these against integer arithmetic.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int NIB = 4;
  localparam int ZW  = NIB + 1;

  typedef logic [NIB-1:0] digit_t;
  typedef logic [ZW-1:0]  zsum_t;

  function automatic zsum_t raw_total(input digit_t x, input digit_t y, input logic c);
    raw_total = zsum_t'(x) + zsum_t'(y) + zsum_t'(c);
  endfunction

  function automatic logic over_nine(input zsum_t z);
    over_nine = z[4] | (z[3] & z[2]) | (z[3] & z[1]);
  endfunction

  function automatic digit_t fixed_digit(input zsum_t z, input logic fix);
    fixed_digit = fix ? (z[NIB-1:0] + digit_t'(6)) : z[NIB-1:0];
  endfunction

  function automatic digit_t nines_of(input digit_t d);
    nines_of = digit_t'(9) - d;
  endfunction

  function automatic logic nibble_bad(input digit_t d);
    nibble_bad = d[3] & (d[2] | d[1]);
  endfunction
endpackage

// File: rtl/bcd_nines_map.sv
module bcd_nines_map #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0] b_i,
  input  logic         en_i,
  output logic [W-1:0] b_o
);
  import bcd_pkg::*;
  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    digit_t d_in;
    assign d_in = b_i[g*NIB +: NIB];
    assign b_o[g*NIB +: NIB] = en_i ? nines_of(d_in) : d_in;
  end
endmodule

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage (
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       c_i,
  output logic [3:0] s_o,
  output logic       c_o,
  output logic [4:0] z_o
);
  import bcd_pkg::*;
  zsum_t z;
  logic  fix;
  assign z   = raw_total(a_i, b_i, c_i);
  assign fix = over_nine(z);
  assign s_o = fixed_digit(z, fix);
  assign c_o = fix;
  assign z_o = z;
endmodule

// File: rtl/bcd_digit_screen.sv
module bcd_digit_screen #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         bad_o
);
  import bcd_pkg::*;
  logic [2*DIGITS-1:0] hit;
  for (genvar g = 0; g < DIGITS; g++) begin : g_scan
    assign hit[2*g]   = nibble_bad(a_i[g*NIB +: NIB]);
    assign hit[2*g+1] = nibble_bad(b_i[g*NIB +: NIB]);
  end
  assign bad_o = |hit;
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         bad_digit_o
);
  import bcd_pkg::*;

  logic [W-1:0]              b_eff;
  logic [DIGITS:0]           carry;
  logic [DIGITS-1:0][ZW-1:0] z_raw;

  bcd_nines_map #(.DIGITS(DIGITS)) u_map (
    .b_i (b_i),
    .en_i(sub_i),
    .b_o (b_eff)
  );

  bcd_digit_screen #(.DIGITS(DIGITS)) u_screen (
    .a_i  (a_i),
    .b_i  (b_i),
    .bad_o(bad_digit_o)
  );

  assign carry[0] = sub_i | cin_i & ~sub_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_stage
    bcd_digit_stage u_stage (
      .a_i(a_i[g*NIB +: NIB]),
      .b_i(b_eff[g*NIB +: NIB]),
      .c_i(carry[g]),
      .s_o(sum_o[g*NIB +: NIB]),
      .c_o(carry[g+1]),
      .z_o(z_raw[g])
    );
  end

  assign cout_o = carry[DIGITS];
endmodule

// File: rtl/bcd_addsub_chk.sv
module bcd_addsub_chk #(
  parameter int DIGITS = 4,
  localparam int W = 4 * DIGITS
) (
  input logic [W-1:0]            a_i,
  input logic [W-1:0]            b_i,
  input logic                    sub_i,
  input logic                    cin_i,
  input logic [W-1:0]            sum_o,
  input logic                    cout_o,
  input logic                    bad_digit_o,
  input logic [DIGITS:0]         carry,
  input logic [DIGITS-1:0][4:0]  z_raw
);
  logic any_bad;
  always_comb begin
    any_bad = 1'b0;
    for (int i = 0; i < DIGITS; i++) begin
      if (a_i[4*i +: 4] > 4'd9 || b_i[4*i +: 4] > 4'd9) any_bad = 1'b1;
    end
  end

  always_comb begin
    AST_BAD_FLAG: assert (bad_digit_o == any_bad) else $error("bad flag mismatch"); // R7
    AST_COUT_CHAIN: assert (cout_o == carry[DIGITS]) else $error("cout not top carry"); // R4
    if (sub_i) begin
      AST_SUB_SEED: assert (carry[0] == 1'b1) else $error("subtract seed missing"); // R5
    end else begin
      AST_ADD_SEED: assert (carry[0] == cin_i) else $error("add seed wrong"); // R1
    end
    for (int i = 0; i < DIGITS; i++) begin
      AST_CARRY_OVER_NINE: assert (carry[i+1] == (z_raw[i] > 5'd9)) else $error("digit carry wrong"); // R3
      if (!any_bad) begin
        AST_Z_MAX: assert (z_raw[i] <= 5'd19) else $error("digit total too big"); // R3
        AST_DIGIT_RANGE: assert (sum_o[4*i +: 4] <= 4'd9) else $error("digit out of range"); // R2
        AST_DIGIT_VALUE: assert ({1'b0, sum_o[4*i +: 4]} ==
                                 ((z_raw[i] > 5'd9) ? z_raw[i] - 5'd10 : z_raw[i]))
          else $error("digit value wrong"); // R3
      end
    end
  end
endmodule

bind bcd_addsub bcd_addsub_chk #(.DIGITS(DIGITS)) u_chk (
  .a_i(a_i), .b_i(b_i), .sub_i(sub_i), .cin_i(cin_i),
  .sum_o(sum_o), .cout_o(cout_o), .bad_digit_o(bad_digit_o),
  .carry(carry), .z_raw(z_raw)
);

// File: tb/tb_bcd_addsub.sv
module tb_bcd_addsub;
  localparam int DIGITS = 4;
  localparam int W = 4 * DIGITS;
  localparam int MODV = 10000;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  localparam int VA  [NVEC] = '{0, 1234, 5, 9, 9999, 4999, 5000, 1234, 0, 9999, 7777, 8888};
  localparam int VB  [NVEC] = '{0, 4321, 5, 9, 1,    5001, 1234, 5000, 1, 1234, 7777, 1111};
  localparam int VS  [NVEC] = '{0, 0,    0, 0, 0,    0,    1,    1,    1, 1,    1,    0};
  localparam int VC  [NVEC] = '{0, 0,    0, 1, 0,    0,    0,    0,    0, 0,    1,    1};

  logic clk = 1'b0;
  logic [W-1:0] a, b, sum;
  logic sub, cin, cout, bad;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_addsub #(.DIGITS(DIGITS)) dut (
    .a_i(a), .b_i(b), .sub_i(sub), .cin_i(cin),
    .sum_o(sum), .cout_o(cout), .bad_digit_o(bad)
  );

  function automatic logic [W-1:0] to_bcd(input int v);
    logic [W-1:0] r = '0;
    int t = v;
    for (int i = 0; i < DIGITS; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input int va, input int vb, input int vs, input int vc, input string req);
    int s;
    logic ec;
    a = to_bcd(va); b = to_bcd(vb); sub = vs[0]; cin = vc[0];
    #1;
    if (vs != 0) begin
      s = va + MODV - vb;
      ec = (va >= vb);
    end else begin
      s = va + vb + vc;
      ec = (s >= MODV);
    end
    check(req, sum, to_bcd(s % MODV));
    check(req, W'(cout), W'(ec));
    check({req, " R7 clean"}, W'(bad), W'(0));
    @(negedge clk);
  endtask

  initial begin
    int rnd;
    logic [W-1:0] nines;
    a = '0; b = '0; sub = 1'b0; cin = 1'b0;
    @(negedge clk);
    // idle state: all-zero inputs give zero result
    check("R1 idle", sum, '0);
    check("R1 idle cout", W'(cout), W'(0));

    for (int i = 0; i < NVEC; i++) begin
      run(VA[i], VB[i], VS[i], VC[i], VS[i] != 0 ? "R5 table" : "R1 table");
    end

    // R3: 9+9+1 yields digit 9 with carry into next digit
    a = to_bcd(9); b = to_bcd(9); sub = 1'b0; cin = 1'b1; #1;
    check("R3 max digit", sum, to_bcd(19));
    // R4: ripple through all nines
    a = to_bcd(9999); b = to_bcd(1); cin = 1'b0; #1;
    check("R4 ripple", sum, '0);
    check("R4 ripple cout", W'(cout), W'(1));
    // R6: 0-1 tens complement
    a = to_bcd(0); b = to_bcd(1); sub = 1'b1; #1;
    check("R6 tens complement", sum, to_bcd(9999));
    check("R6 borrow", W'(cout), W'(0));
    // R5: cin has no effect when subtracting
    a = to_bcd(4321); b = to_bcd(1111); cin = 1'b0; #1;
    check("R5 cin0", sum, to_bcd(3210));
    cin = 1'b1; #1;
    check("R5 cin ignored", sum, to_bcd(3210));
    // R8: nines complement per digit
    for (int d = 0; d < 10; d++) begin
      a = to_bcd(9999); b = to_bcd(d * 1111); sub = 1'b1; cin = 1'b0; #1;
      check("R8 nines map", sum, to_bcd((9 - d) * 1111));
      check("R8 cout", W'(cout), W'(1));
    end
    // R2 sweep with an LFSR over valid operands, both modes
    rnd = 32'h1ACE;
    for (int i = 0; i < 300; i++) begin
      int x, y;
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >>> 17); rnd = rnd ^ (rnd << 5);
      x = (rnd & 32'h7FFF_FFFF) % MODV;
      y = ((rnd >>> 7) & 32'h00FF_FFFF) % MODV;
      run(x, y, (rnd >>> 3) & 1, (rnd >>> 4) & 1, (((rnd >>> 3) & 1) != 0) ? "R5 R2 sweep" : "R1 R2 sweep");
      for (int k = 0; k < DIGITS; k++) begin
        a = to_bcd(x); b = to_bcd(y); #1;
        checks++;
        if (sum[4*k +: 4] > 4'd9) begin
          errors++;
          $display("FAIL R2: actual %h expected digit <= 9", sum[4*k +: 4]);
        end
      end
    end
    // R7: invalid nibbles flagged in either operand and either mode
    a = 16'h00A0; b = 16'h0000; sub = 1'b0; #1;
    check("R7 a nibble", W'(bad), W'(1));
    a = 16'h0000; b = 16'hF000; sub = 1'b1; #1;
    check("R7 b nibble sub", W'(bad), W'(1));
    a = 16'h9999; b = 16'h9999; sub = 1'b0; #1;
    check("R7 nine ok", W'(bad), W'(0));
    a = 16'h000C; b = 16'h0000; #1;
    check("R7 low nibble", W'(bad), W'(1));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule